// File: doc/BRIEF.md
# Interleaved SECDED Row Protection Unit

This unit protects one physical storage row that holds four 64-bit data words. On the write side each word is expanded into a 72-bit extended Hamming codeword. The four codewords are then woven bit by bit into a single 288-bit row, so any two neighbouring row bits always belong to different words. The write path is purely combinational, and the storage array captures the row directly.

On the read side a 288-bit row is unwoven back into four codewords, and each codeword is checked on its own. A word with one flipped bit is repaired. A word with two flipped bits is flagged as uncorrectable, and its data bits are returned exactly as they were stored. Corrected data and a 2-bit status per word are registered and presented one cycle after the read request, together with a valid strobe. Because of the weaving, a strike that flips up to four adjacent row bits shows up as at most one error per word, and every word is then corrected.

Top module: `ileave_ecc_row`

## Requirements
- R1: `wr_row` bit `4*j+k` carries bit `j` of the codeword for word `k` (word `k` is `wr_data[64k+63:64k]`). In a codeword, bits 1, 2, 4, 8, 16, 32 and 64 are Hamming checks, where check `2^i` makes the XOR of all bits 1..71 whose index has bit `i` set equal to zero. Bit 0 is even parity over bits 1..71. Data bits 0..63 fill the remaining positions 3, 5, 6, 7, 9 and onward in ascending order.
- R2: A row with no flipped bits returns every word unchanged, with status 2'b00 (clean).
- R3: A single flipped data bit or Hamming check bit in a codeword returns the original word, with status 2'b01 (corrected).
- R4: A flip of codeword bit 0 alone returns the original word, with status 2'b01.
- R5: Two flipped bits in one codeword give status 2'b10 (uncorrectable), and the returned word equals the data bits read from the stored row, unaltered.
- R6: A burst of one to four adjacent flipped row bits returns all four words correct, with status 2'b01 on each touched word and 2'b00 on the others.
- R7: `rd_valid` is high in exactly the cycle after a cycle with `rd_req` high. `rd_data` and `rd_status` for that request are valid in that cycle.
- R8: Words are judged independently: an uncorrectable word and a corrected word in the same row each get their own status. Status 2'b11 never appears.
- R9: During and right after reset, `rd_valid` is 0 and `rd_data` and `rd_status` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 256 | Four data words to encode, word k in bits 64k+63:64k |
| wr_row | output | 288 | Interleaved encoded row, combinational |
| rd_req | input | 1 | Read row is present this cycle |
| rd_row | input | 288 | Interleaved row read from storage |
| rd_valid | output | 1 | Registered results are valid |
| rd_data | output | 256 | Corrected words, word k in bits 64k+63:64k |
| rd_status | output | 8 | Per-word status, word k in bits 2k+1:2k |

## Verification
The encode path and the decode path work in the same cycle, and inside one decode, different words can be repaired and rejected at the same time. The bench drives fresh random write data in every cycle that carries a read request, then checks the combinational row and the registered read results in the same step. Some rows combine a double error in one word with a single error in another. The expected status and data for each word are worked out from the number of flipped bits that land in that word.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W = 64;
    localparam int HAM_W  = 7;
    localparam int CW_W   = DATA_W + HAM_W + 1;
    localparam int LANES  = 4;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_FATAL = 2'b10
    } ecc_stat_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        ecc_stat_e         stat;
    } lane_res_t;

    function automatic logic is_chk_pos(input int p);
        return ((p & (p - 1)) == 0);
    endfunction

    // spread data into the non-power-of-two positions 3..71
    function automatic logic [CW_W-1:0] ham_place(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0] cw;
        int idx;
        cw  = '0;
        idx = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_chk_pos(p)) begin
                cw[p] = d[idx];
                idx++;
            end
        end
        return cw;
    endfunction

    function automatic logic [DATA_W-1:0] ham_extract(input logic [CW_W-1:0] cw);
        logic [DATA_W-1:0] d;
        int idx;
        d   = '0;
        idx = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_chk_pos(p)) begin
                d[idx] = cw[p];
                idx++;
            end
        end
        return d;
    endfunction

    function automatic logic [HAM_W-1:0] ham_syndrome(input logic [CW_W-1:0] cw);
        logic [HAM_W-1:0] s;
        s = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (cw[p]) s = s ^ HAM_W'(p);
        end
        return s;
    endfunction

    function automatic logic [CW_W-1:0] ham_encode(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0]  cw;
        logic [HAM_W-1:0] s;
        cw = ham_place(d);
        s  = ham_syndrome(cw);
        for (int i = 0; i < HAM_W; i++) begin
            cw[1 << i] = s[i];
        end
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

endpackage

// File: rtl/secded_lane_enc.sv
module secded_lane_enc
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);
    always_comb begin
        cw_o = ham_encode(data_i);
    end
endmodule

// File: rtl/secded_lane_dec.sv
module secded_lane_dec
    import secded_pkg::*;
(
    input  logic [CW_W-1:0]   cw_i,
    output lane_res_t         res_o,
    output logic [DATA_W-1:0] raw_o
);
    logic [HAM_W-1:0] syn;
    logic             par_miss;
    logic [CW_W-1:0]  fixed;

    always_comb begin
        syn      = ham_syndrome(cw_i);
        par_miss = ^cw_i;
        fixed    = cw_i;
        res_o.stat = ST_CLEAN;
        if (syn != '0 && par_miss) begin
            // odd error count: single if syndrome points inside the word
            if (syn <= HAM_W'(CW_W - 1)) begin
                fixed[syn] = ~cw_i[syn];
                res_o.stat = ST_FIXED;
            end else begin
                res_o.stat = ST_FATAL;
            end
        end else if (syn != '0) begin
            res_o.stat = ST_FATAL;
        end else if (par_miss) begin
            fixed[0]   = ~cw_i[0];
            res_o.stat = ST_FIXED;
        end
        raw_o      = ham_extract(cw_i);
        res_o.data = (res_o.stat == ST_FATAL) ? raw_o : ham_extract(fixed);
    end
endmodule

// File: rtl/row_weave.sv
module row_weave
    import secded_pkg::*;
#(
    parameter int NLANE = LANES,
    parameter bit UNWEAVE = 1'b0
) (
    input  logic [NLANE*CW_W-1:0] in_i,
    output logic [NLANE*CW_W-1:0] out_o
);
    // lane-major vector: lane k bit j at k*CW_W+j; row: at NLANE*j+k
    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        for (genvar j = 0; j < CW_W; j++) begin : g_bit
            if (UNWEAVE) begin : g_un
                assign out_o[k*CW_W+j] = in_i[NLANE*j+k];
            end else begin : g_wv
                assign out_o[NLANE*j+k] = in_i[k*CW_W+j];
            end
        end
    end
endmodule

// File: rtl/ileave_ecc_row.sv
module ileave_ecc_row
    import secded_pkg::*;
#(
    parameter int NLANE = LANES,
    localparam int ROW_W = NLANE * CW_W,
    localparam int BUS_W = NLANE * DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] wr_data,
    output logic [ROW_W-1:0] wr_row,
    input  logic             rd_req,
    input  logic [ROW_W-1:0] rd_row,
    output logic             rd_valid,
    output logic [BUS_W-1:0] rd_data,
    output logic [2*NLANE-1:0] rd_status
);
    logic [ROW_W-1:0]  enc_lanes;
    logic [ROW_W-1:0]  dec_lanes;
    lane_res_t         dec_res [NLANE];
    logic [DATA_W-1:0] dec_raw [NLANE];

    for (genvar k = 0; k < NLANE; k++) begin : g_codec
        secded_lane_enc u_enc (
            .data_i (wr_data[k*DATA_W +: DATA_W]),
            .cw_o   (enc_lanes[k*CW_W +: CW_W])
        );
        secded_lane_dec u_dec (
            .cw_i   (dec_lanes[k*CW_W +: CW_W]),
            .res_o  (dec_res[k]),
            .raw_o  (dec_raw[k])
        );
    end

    row_weave #(.NLANE(NLANE), .UNWEAVE(1'b0)) u_weave (
        .in_i  (enc_lanes),
        .out_o (wr_row)
    );

    row_weave #(.NLANE(NLANE), .UNWEAVE(1'b1)) u_unweave (
        .in_i  (rd_row),
        .out_o (dec_lanes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            rd_status <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                for (int k = 0; k < NLANE; k++) begin
                    rd_data[k*DATA_W +: DATA_W] <= dec_res[k].data;
                    rd_status[2*k +: 2]         <= dec_res[k].stat;
                end
            end
        end
    end

    // R7: valid follows the request by exactly one cycle
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);
    a_r7_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    for (genvar k = 0; k < NLANE; k++) begin : g_chk
        // R8: the unused status code never reaches the output
        a_r8_no_code3: assert property (@(posedge clk) disable iff (rst)
            rd_valid |-> rd_status[2*k +: 2] != 2'b11);
        // R5: uncorrectable words leave the stored data untouched
        a_r5_fatal_raw: assert property (@(posedge clk) disable iff (rst)
            (rd_req && dec_res[k].stat == ST_FATAL) |-> dec_res[k].data == dec_raw[k]);
        // R2: clean words pass through unchanged
        a_r2_clean_raw: assert property (@(posedge clk) disable iff (rst)
            (rd_req && dec_res[k].stat == ST_CLEAN) |-> dec_res[k].data == dec_raw[k]);
        // R3: a correction changes at most one data bit
        a_r3_one_flip: assert property (@(posedge clk) disable iff (rst)
            (rd_req && dec_res[k].stat == ST_FIXED) |->
                $countones(dec_res[k].data ^ dec_raw[k]) <= 1);
    end
endmodule

// File: tb/ileave_ecc_row_tb.sv
module ileave_ecc_row_tb;
    localparam int DW = 64;
    localparam int CW = 72;
    localparam int NL = 4;
    localparam int RW = NL * CW;
    localparam int BW = NL * DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [BW-1:0] wr_data = '0;
    logic [RW-1:0] wr_row;
    logic          rd_req = 1'b0;
    logic [RW-1:0] rd_row = '0;
    logic          rd_valid;
    logic [BW-1:0] rd_data;
    logic [2*NL-1:0] rd_status;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ileave_ecc_row u_dut (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_row(wr_row),
        .rd_req(rd_req), .rd_row(rd_row), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_status(rd_status)
    );

    task automatic check(input logic ok, input string req,
                         input logic [RW-1:0] act, input logic [RW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] b_enc(input logic [DW-1:0] d);
        logic [CW-1:0] cw;
        int idx;
        cw = '0;
        idx = 0;
        for (int p = 1; p < CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[idx];
                idx++;
            end
        end
        for (int i = 0; i < 7; i++) begin
            logic c;
            c = 1'b0;
            for (int p = 1; p < CW; p++) begin
                if (((p >> i) & 1) == 1 && p != (1 << i)) c ^= cw[p];
            end
            cw[1 << i] = c;
        end
        cw[0] = ^cw[CW-1:1];
        return cw;
    endfunction

    function automatic logic [DW-1:0] b_data(input logic [CW-1:0] cw);
        logic [DW-1:0] d;
        int idx;
        d = '0;
        idx = 0;
        for (int p = 1; p < CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[idx] = cw[p];
                idx++;
            end
        end
        return d;
    endfunction

    function automatic logic [RW-1:0] b_row(input logic [BW-1:0] w);
        logic [RW-1:0] r;
        for (int k = 0; k < NL; k++) begin
            logic [CW-1:0] cw;
            cw = b_enc(w[k*DW +: DW]);
            for (int j = 0; j < CW; j++) r[NL*j+k] = cw[j];
        end
        return r;
    endfunction

    function automatic logic [BW-1:0] rnd_words();
        logic [BW-1:0] w;
        for (int i = 0; i < BW / 32; i++) w[i*32 +: 32] = $urandom;
        return w;
    endfunction

    // one read with flip mask; a fresh write runs in the same cycle (R1)
    task automatic do_read(input logic [BW-1:0] words, input logic [RW-1:0] mask,
                           input string req);
        logic [RW-1:0] row;
        logic [BW-1:0] exp_d;
        logic [2*NL-1:0] exp_s;
        logic [BW-1:0] wd;
        row = b_row(words) ^ mask;
        for (int k = 0; k < NL; k++) begin
            int nf;
            logic [CW-1:0] cw;
            nf = 0;
            for (int j = 0; j < CW; j++) begin
                nf += int'(mask[NL*j+k]);
                cw[j] = row[NL*j+k];
            end
            if (nf == 0) begin
                exp_s[2*k +: 2] = 2'b00;
                exp_d[k*DW +: DW] = words[k*DW +: DW];
            end else if (nf == 1) begin
                exp_s[2*k +: 2] = 2'b01;
                exp_d[k*DW +: DW] = words[k*DW +: DW];
            end else begin
                exp_s[2*k +: 2] = 2'b10;
                exp_d[k*DW +: DW] = b_data(cw);
            end
        end
        wd = rnd_words();
        @(negedge clk);
        rd_req  = 1'b1;
        rd_row  = row;
        wr_data = wd;
        #1;
        check(wr_row == b_row(wd), "R1 encode+weave", wr_row, b_row(wd));
        @(posedge clk);
        #2;
        check(rd_valid === 1'b1, "R7 valid", {287'd0, rd_valid}, 288'd1);
        check(rd_status === exp_s, {req, " status"}, {280'd0, rd_status}, {280'd0, exp_s});
        check(rd_data === exp_d, {req, " data"}, {32'd0, rd_data}, {32'd0, exp_d});
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [RW-1:0] m;
        logic [BW-1:0] w;
        void'($urandom(32'd9157));
        repeat (3) @(posedge clk);
        #2;
        check(rd_valid === 1'b0 && rd_data === '0 && rd_status === '0, "R9 reset",
              {rd_data, 23'd0, rd_valid, rd_status}, '0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check(rd_valid === 1'b0 && rd_status === '0, "R9 after reset",
              {279'd0, rd_valid, rd_status}, '0);

        // directed corners
        do_read('0, '0, "R2 zeros");
        do_read('1, '0, "R2 ones");
        m = '0; m[0] = 1'b1;
        do_read('1, m, "R4 parity bit lane0");
        m = '0; m[NL*71+3] = 1'b1;
        do_read(rnd_words(), m, "R3 top bit lane3");
        m = '0; m[NL*64+2] = 1'b1;
        do_read(rnd_words(), m, "R3 check bit lane2");
        m = '0; m[3:0] = 4'hF;
        do_read(rnd_words(), m, "R6 burst4 at 0");
        m = '0; m[RW-1 -: 4] = 4'hF;
        do_read(rnd_words(), m, "R6 burst4 at top");
        m = '0; m[NL*5+1] = 1'b1; m[NL*40+1] = 1'b1; m[NL*9+2] = 1'b1;
        do_read(rnd_words(), m, "R8 mixed lanes");
        m = '0; m[0] = 1'b1; m[NL*1] = 1'b1;
        do_read(rnd_words(), m, "R5 parity+check");

        // idle cycle: valid must drop (R7)
        @(posedge clk);
        #2;
        check(rd_valid === 1'b0, "R7 idle", {287'd0, rd_valid}, '0);

        // random
        for (int t = 0; t < 400; t++) begin
            int kind;
            w = rnd_words();
            m = '0;
            kind = $urandom_range(0, 4);
            if (kind == 0) begin
                do_read(w, m, "R2 random clean");
            end else if (kind == 1) begin
                m[NL * $urandom_range(0, CW - 1) + $urandom_range(0, NL - 1)] = 1'b1;
                do_read(w, m, "R3 random single");
            end else if (kind == 2) begin
                int k, a, b;
                k = $urandom_range(0, NL - 1);
                a = $urandom_range(0, CW - 1);
                b = (a + $urandom_range(1, CW - 1)) % CW;
                m[NL*a+k] = 1'b1;
                m[NL*b+k] = 1'b1;
                do_read(w, m, "R5 random double");
            end else if (kind == 3) begin
                int s, len;
                len = $urandom_range(1, 4);
                s = $urandom_range(0, RW - len);
                for (int i = 0; i < len; i++) m[s+i] = 1'b1;
                do_read(w, m, "R6 random burst");
            end else begin
                int ka, kb, a, b;
                ka = $urandom_range(0, NL - 1);
                kb = (ka + $urandom_range(1, NL - 1)) % NL;
                a = $urandom_range(0, CW - 1);
                b = (a + $urandom_range(1, CW - 1)) % CW;
                m[NL*a+ka] = 1'b1;
                m[NL*b+ka] = 1'b1;
                m[NL * $urandom_range(0, CW - 1) + kb] = 1'b1;
                do_read(w, m, "R8 random mixed");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule